// File: doc/BRIEF.md
# Instruction Queue Tracking Monitor

This block watches a processor from the outside and rebuilds the contents of its instruction prefetch queue. The processor drives a 2-bit status bus whose meaning depends on the phase of its bus clock. At a rising bus-clock edge the bus carries a data-movement code. At a falling edge it carries an execution-start code. The monitor also samples the external 16-bit data bus, so it can follow the words that move into a holding latch and through two queue stages.

Everything runs on one fast system clock. A synchronizer finds the bus-clock edges, and the status and data pins are sampled in the cycle where an edge is detected. A rising edge with a non-zero movement code updates the queue model and emits a movement trace event. A falling edge with a non-zero start code emits a start trace event. That event carries the start type, the opcode byte taken from the head stage, the whole head word, and a flag that is set when the queue has not yet been filled since reset.

Top module: `iqt_trace_mon`

## Requirements
- R1: A synchronous active-high reset clears the holding latch, both queue stages, the parked bus word, the advance counter and both valid strobes. An even start seen right after reset reports opcode 0 and head word 0.
- R2: `bus_clk_in` passes through a two-flop synchronizer. Each rising edge of the synchronized bus clock causes exactly one evaluation of the movement code. Each falling edge causes exactly one evaluation of the start code.
- R3: On every falling bus-clock edge the data bus is parked in a register. Movement codes at the next rising edge use that parked word, not the live bus.
- R4: Movement code 2'b01 copies the parked word into the holding latch and leaves the queue stages unchanged.
- R5: Movement code 2'b10 shifts stage 1 into stage 0 and loads stage 1 with the parked word.
- R6: Movement code 2'b11 shifts stage 1 into stage 0 and loads stage 1 from the holding latch. The latch keeps its value.
- R7: Movement code 2'b00 changes no state and produces no movement event.
- R8: Each non-zero movement code produces `mv_valid` high for one system cycle, with `mv_code` equal to that code.
- R9: Start code 2'b10 (even) reports bits 15:8 of stage 0 as the opcode. Start code 2'b11 (odd) reports bits 7:0. Start code 2'b01 (interrupt) reports opcode 0. Every start event carries `start_kind` equal to the code and `start_head` equal to stage 0.
- R10: Start code 2'b00 produces no start event. A start event is one system cycle wide.
- R11: `start_unprimed` is 1 on a start event when fewer than two queue advances (codes 2'b10 or 2'b11) have happened since reset, and 0 otherwise.
- R12: `mv_valid` and `start_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_in | input | 1 | Processor bus clock, asynchronous to clk |
| status_in | input | 2 | Time-multiplexed queue status pins |
| data_in | input | 16 | External data bus |
| mv_valid | output | 1 | One-cycle strobe for a movement event |
| mv_code | output | 2 | Movement code of the event |
| start_valid | output | 1 | One-cycle strobe for a start event |
| start_kind | output | 2 | Start code: 01 interrupt, 10 even, 11 odd |
| start_opcode | output | 8 | Opcode byte selected from stage 0 |
| start_head | output | 16 | Stage 0 word at the start |
| start_unprimed | output | 1 | Queue had fewer than two advances since reset |

## Verification
The assertions assume that each bus-clock half period lasts several system cycles. Under that assumption a strobe cannot repeat on the next cycle, and rising and falling detections cannot coincide. They also assume that status and data stay stable through the synchronizer delay after each edge. The bench meets these assumptions by changing the pins only on the falling edge of the system clock, together with the bus-clock level, and by holding every half period for eight system cycles. That is far longer than the three-cycle detection path.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
  typedef enum logic [1:0] {
    MV_NONE      = 2'b00,
    MV_PARK      = 2'b01,
    MV_ADV_BUS   = 2'b10,
    MV_ADV_LATCH = 2'b11
  } mv_code_e;

  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_INT  = 2'b01,
    ST_EVEN = 2'b10,
    ST_ODD  = 2'b11
  } start_code_e;
endpackage

// File: rtl/iqt_bus_edge.sv
module iqt_bus_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_clk_in,
  output logic rise_o,
  output logic fall_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], bus_clk_in};
      last_q <= sync_q[MSB];
    end
  end

  assign rise_o = sync_q[MSB] & ~last_q;
  assign fall_o = ~sync_q[MSB] & last_q;
endmodule

// File: rtl/iqt_queue_model.sv
module iqt_queue_model
  import iqt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int Q_STAGES    = 2,
  parameter int PRIME_ADV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [1:0]        status_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o,
  output logic              primed_o,
  output logic              mv_valid_o,
  output logic [1:0]        mv_code_o
);
  localparam int CNT_W = $clog2(PRIME_ADV + 1);
  localparam logic [CNT_W-1:0] PRIME_LIM = CNT_W'(PRIME_ADV);

  mv_code_e          code;
  logic              advance;
  logic              park;
  logic [DATA_W-1:0] parked_q;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] fill;
  logic [DATA_W-1:0] stage_q [Q_STAGES];
  logic [CNT_W-1:0]  adv_cnt_q;

  assign code    = mv_code_e'(status_i);
  assign advance = rise_i && (code == MV_ADV_BUS || code == MV_ADV_LATCH);
  assign park    = rise_i && (code == MV_PARK);
  assign fill    = (code == MV_ADV_LATCH) ? latch_q : parked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      parked_q <= '0;
      latch_q  <= '0;
    end else begin
      if (fall_i) parked_q <= data_i;
      if (park)   latch_q  <= parked_q;
    end
  end

  for (genvar i = 0; i < Q_STAGES; i++) begin : g_stage
    if (i == Q_STAGES - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)          stage_q[i] <= '0;
        else if (advance) stage_q[i] <= fill;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)          stage_q[i] <= '0;
        else if (advance) stage_q[i] <= stage_q[i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_cnt_q  <= '0;
      mv_valid_o <= 1'b0;
      mv_code_o  <= 2'b00;
    end else begin
      if (advance && adv_cnt_q != PRIME_LIM) adv_cnt_q <= adv_cnt_q + 1'b1;
      mv_valid_o <= rise_i && (code != MV_NONE);
      if (rise_i && code != MV_NONE) mv_code_o <= status_i;
    end
  end

  assign head_o   = stage_q[0];
  assign primed_o = (adv_cnt_q == PRIME_LIM);
endmodule

// File: rtl/iqt_start_report.sv
module iqt_start_report
  import iqt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  logic [1:0]        status_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              primed_i,
  output logic              start_valid_o,
  output logic [1:0]        start_kind_o,
  output logic [7:0]        start_opcode_o,
  output logic [DATA_W-1:0] start_head_o,
  output logic              start_unprimed_o
);
  start_code_e code;
  logic [7:0]  opcode;
  logic        fire;

  assign code = start_code_e'(status_i);
  assign fire = fall_i && (code != ST_NONE);

  always_comb begin
    unique case (code)
      ST_EVEN: opcode = head_i[DATA_W-1 -: 8];
      ST_ODD:  opcode = head_i[7:0];
      default: opcode = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_valid_o    <= 1'b0;
      start_kind_o     <= 2'b00;
      start_opcode_o   <= 8'h00;
      start_head_o     <= '0;
      start_unprimed_o <= 1'b0;
    end else begin
      start_valid_o <= fire;
      if (fire) begin
        start_kind_o     <= status_i;
        start_opcode_o   <= opcode;
        start_head_o     <= head_i;
        start_unprimed_o <= ~primed_i;
      end
    end
  end
endmodule

// File: rtl/iqt_trace_mon.sv
module iqt_trace_mon #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int Q_STAGES    = 2,
  parameter int PRIME_ADV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk_in,
  input  logic [1:0]        status_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              mv_valid,
  output logic [1:0]        mv_code,
  output logic              start_valid,
  output logic [1:0]        start_kind,
  output logic [7:0]        start_opcode,
  output logic [DATA_W-1:0] start_head,
  output logic              start_unprimed
);
  logic              rise;
  logic              fall;
  logic [DATA_W-1:0] head;
  logic              primed;

  iqt_bus_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .bus_clk_in (bus_clk_in),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  iqt_queue_model #(
    .DATA_W    (DATA_W),
    .Q_STAGES  (Q_STAGES),
    .PRIME_ADV (PRIME_ADV)
  ) u_queue (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .fall_i     (fall),
    .status_i   (status_in),
    .data_i     (data_in),
    .head_o     (head),
    .primed_o   (primed),
    .mv_valid_o (mv_valid),
    .mv_code_o  (mv_code)
  );

  iqt_start_report #(.DATA_W(DATA_W)) u_start (
    .clk              (clk),
    .rst              (rst),
    .fall_i           (fall),
    .status_i         (status_in),
    .head_i           (head),
    .primed_i         (primed),
    .start_valid_o    (start_valid),
    .start_kind_o     (start_kind),
    .start_opcode_o   (start_opcode),
    .start_head_o     (start_head),
    .start_unprimed_o (start_unprimed)
  );
endmodule

// File: rtl/iqt_trace_mon_chk.sv
module iqt_trace_mon_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mv_valid,
  input logic [1:0]        mv_code,
  input logic              start_valid,
  input logic [1:0]        start_kind,
  input logic [7:0]        start_opcode,
  input logic [DATA_W-1:0] start_head
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!mv_valid && !start_valid));

  // R8
  mv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mv_valid |=> !mv_valid);

  // R7
  mv_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> (mv_code != 2'b00));

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);

  // R10
  start_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> (start_kind != 2'b00));

  // R9
  even_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_kind == 2'b10) |-> (start_opcode == start_head[DATA_W-1 -: 8]));

  // R9
  odd_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_kind == 2'b11) |-> (start_opcode == start_head[7:0]));

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(mv_valid && start_valid));
endmodule

bind iqt_trace_mon iqt_trace_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mv_valid     (mv_valid),
  .mv_code      (mv_code),
  .start_valid  (start_valid),
  .start_kind   (start_kind),
  .start_opcode (start_opcode),
  .start_head   (start_head)
);

// File: tb/iqt_trace_mon_tb.sv
`timescale 1ns/1ps
module iqt_trace_mon_tb;
  localparam int DATA_W = 16;
  localparam int HALF   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_clk_in = 1'b0;
  logic [1:0]        status_in = 2'b00;
  logic [DATA_W-1:0] data_in = '0;
  logic              mv_valid, start_valid, start_unprimed;
  logic [1:0]        mv_code, start_kind;
  logic [7:0]        start_opcode;
  logic [DATA_W-1:0] start_head;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  iqt_trace_mon u_dut (
    .clk(clk), .rst(rst), .bus_clk_in(bus_clk_in), .status_in(status_in),
    .data_in(data_in), .mv_valid(mv_valid), .mv_code(mv_code),
    .start_valid(start_valid), .start_kind(start_kind),
    .start_opcode(start_opcode), .start_head(start_head),
    .start_unprimed(start_unprimed)
  );

  // reference queue model
  logic [DATA_W-1:0] m_parked, m_latch, m_st0, m_st1;
  int                m_adv;
  logic [1:0]        exp_mv[$];
  logic [26:0]       exp_st[$];   // {unprimed, kind, opcode, head}

  task automatic model_reset();
    m_parked = '0; m_latch = '0; m_st0 = '0; m_st1 = '0; m_adv = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // falling half: start code, bus word parked (R3)
  task automatic fall_phase(input logic [1:0] st, input logic [DATA_W-1:0] d);
    logic [7:0] op;
    @(negedge clk);
    bus_clk_in = 1'b0; status_in = st; data_in = d;
    if (st != 2'b00) begin
      op = (st == 2'b10) ? m_st0[15:8] : (st == 2'b11) ? m_st0[7:0] : 8'h00;
      exp_st.push_back({(m_adv < 2), st, op, m_st0});
    end
    m_parked = d;
    wait_clks(HALF);
  endtask

  // rising half: movement code (R4 R5 R6 R7)
  task automatic rise_phase(input logic [1:0] mv);
    @(negedge clk);
    bus_clk_in = 1'b1; status_in = mv; data_in = $urandom;
    case (mv)
      2'b01: m_latch = m_parked;
      2'b10: begin m_st0 = m_st1; m_st1 = m_parked; m_adv++; end
      2'b11: begin m_st0 = m_st1; m_st1 = m_latch;  m_adv++; end
      default: ;
    endcase
    if (mv != 2'b00) exp_mv.push_back(mv);
    wait_clks(HALF);
  endtask

  task automatic bus_cycle(input logic [1:0] st, input logic [DATA_W-1:0] d,
                           input logic [1:0] mv);
    fall_phase(st, d);
    rise_phase(mv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_clk_in = 1'b0; status_in = 2'b00;
    model_reset();
    wait_clks(4);
    // R1: outputs idle during reset
    chk(!mv_valid && !start_valid, "R1", "valid strobes in reset",
        {mv_valid, start_valid}, 0);
    chk(start_head == '0 && start_opcode == 8'h00, "R1", "start fields in reset",
        {start_opcode, start_head}, 0);
    @(negedge clk);
    rst = 1'b0;
    wait_clks(4);
    rise_phase(2'b00);   // bring bus clock high so the next fall is an edge
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      // R12
      if (mv_valid && start_valid) chk(1'b0, "R12", "strobe overlap", 1, 0);
      if (mv_valid) begin
        if (exp_mv.size() == 0) chk(1'b0, "R7", "unexpected movement event", mv_code, 0);
        else begin
          logic [1:0] e;
          e = exp_mv.pop_front();
          chk(mv_code == e, "R8", "movement code", mv_code, e);
        end
      end
      if (start_valid) begin
        if (exp_st.size() == 0) chk(1'b0, "R10", "unexpected start event", start_kind, 0);
        else begin
          logic [26:0] e;
          e = exp_st.pop_front();
          chk(start_kind == e[25:24], "R9", "start kind", start_kind, e[25:24]);
          chk(start_opcode == e[23:16], "R9", "opcode byte", start_opcode, e[23:16]);
          chk(start_head == e[15:0], "R5", "head word", start_head, e[15:0]);
          chk(start_unprimed == e[26], "R11", "unprimed flag", start_unprimed, e[26]);
        end
      end
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 R11: fresh queue, even start reports zeros and unprimed
    bus_cycle(2'b10, 16'hA1B2, 2'b10);   // R5 stage1 <= A1B2
    bus_cycle(2'b11, 16'hC3D4, 2'b10);   // R11 still unprimed at start
    bus_cycle(2'b10, 16'h1122, 2'b01);   // primed, R4 latch <= 1122
    bus_cycle(2'b11, 16'h3344, 2'b00);   // R7 no change
    bus_cycle(2'b10, 16'h5566, 2'b11);   // R6 stage1 <= latch 1122
    bus_cycle(2'b01, 16'h7788, 2'b11);   // R9 interrupt; R6 latch reused
    bus_cycle(2'b00, 16'h99AA, 2'b10);   // R10 no start; R3 parked word used
    bus_cycle(2'b10, 16'hBBCC, 2'b00);
    bus_cycle(2'b11, 16'hDDEE, 2'b00);
    // R2: long stretches with no codes produce nothing
    for (int i = 0; i < 4; i++) bus_cycle(2'b00, 16'h0F0F, 2'b00);
    // mid-run reset: R1 R11
    do_reset();
    bus_cycle(2'b10, 16'h1357, 2'b10);
    bus_cycle(2'b11, 16'h2468, 2'b11);
    bus_cycle(2'b10, 16'hFFFF, 2'b10);
    // random traffic
    for (int i = 0; i < 300; i++)
      bus_cycle(2'($urandom), 16'($urandom), 2'($urandom));
    fall_phase(2'b00, 16'h0);
    wait_clks(6);
    chk(exp_mv.size() == 0, "R2", "missing movement events", exp_mv.size(), 0);
    chk(exp_st.size() == 0, "R2", "missing start events", exp_st.size(), 0);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule